// File: doc/BRIEF.md
# Debug Halt and Resume Controller

This block follows the run state of a small processor core on behalf of a debug port. It knows three states: running, stopped (the low-power wait that follows a STOP instruction) and halted. Halt requests come from four prioritised sources. A core reset indication forces the core into a halt that is held out of reset. A GO strobe from the debug side lets the core run again. While the core is halted the block raises a flag that allows debug commands. It also records which source caused the halt, as a one-hot code that a status register shows in bits 27:24.

When GO is accepted, the block produces a one-cycle resume pulse and a resume-kind code. The kind tells the core where execution restarts:
- at the PC the debugger wrote during this halt;
- in the normal reset exception sequence, if the halt came from reset and no PC was written;
- at the instruction after the STOP, if the halt came out of the stopped state;
- at the current PC in every other case.

The pipeline, the register file and the serial transport are outside this block.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset, run_state_o is 0 (running), halt_code_o is 0, cmd_ok_o is 0, resume_o is 0 and resume_kind_o is 0.
- R2: While running, any bit set in halt_src_i moves the core to halted (run_state_o = 2) one cycle later. halt_code_o then holds a one-hot code naming only the highest-priority set source. Bit 0 (external breakpoint pin) has the highest priority, then bit 1 (hardware trigger), bit 2 (software breakpoint) and bit 3 (fault-on-fault). Code bit i names source bit i.
- R3: While running with no halt source set, stop_exec_i moves the core to stopped (run_state_o = 1) one cycle later.
- R4: While stopped, only halt_src_i bit 0 moves the core to halted, and it reports code 0001. The other sources leave the state stopped and halt_code_o unchanged (default STOP_WAKE_ALL = 0).
- R5: cmd_ok_o is 1 exactly while run_state_o is 2 (halted).
- R6: go_i while halted moves the core to running one cycle later. In that same cycle resume_o pulses high for one cycle and resume_kind_o takes its value, which is held until the next GO:
  - 2 if pc_wr_i was seen during this halt;
  - otherwise 3 if the halt came from core_reset_i;
  - otherwise 1 if the halt was entered from stopped;
  - otherwise 0.
- R7: go_i while running or stopped is ignored: no resume pulse and no state change caused by it.
- R8: The PC-written flag is cleared on every accepted GO and on every halt entry, so a later halt without pc_wr_i never resumes with kind 2.
- R9: halt_code_o holds its value until the next halt entry or sts_clr_i. sts_clr_i clears it to 0. A halt entry in the same cycle as sts_clr_i wins.
- R10: core_reset_i in any state moves the core to halted one cycle later with halt_code_o = 0. It takes priority over every other input.
- R11: Halt sources that arrive while the core is already halted are ignored, and halt_code_o stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_src_i | input | NSRC | Halt requests, bit 0 highest priority |
| stop_exec_i | input | 1 | Core executed a STOP instruction |
| go_i | input | 1 | GO command strobe from the debug port |
| core_reset_i | input | 1 | Core reset; hold the core halted out of reset |
| pc_wr_i | input | 1 | Debugger wrote the PC (counted while halted) |
| sts_clr_i | input | 1 | Read-clear strobe for the halt code |
| run_state_o | output | 2 | 0 running, 1 stopped, 2 halted |
| halt_code_o | output | CODE_W | One-hot cause of the last halt |
| resume_o | output | 1 | One-cycle pulse when the core restarts |
| resume_kind_o | output | 2 | Restart point chosen by the last GO |
| cmd_ok_o | output | 1 | Debug commands allowed (halted) |

## Verification
A wrong state register shows up in the cycle after the bad transition: run_state_o and cmd_ok_o go wrong, and so does the reaction to the next GO. A lost or stale PC-written or entry-context flag stays hidden until the following GO, and then shows as a wrong resume_kind_o. A bad halt-code register shows at once, and the error stays visible until the next halt entry or clear. For this reason the bench compares every output every cycle against a cycle model. It also drives GO sequences after each kind of halt entry.

// File: rtl/dbg_run_pkg.sv
package dbg_run_pkg;
   typedef enum logic [1:0] {
      RS_RUN  = 2'd0,
      RS_STOP = 2'd1,
      RS_HALT = 2'd2
   } run_state_e;

   typedef enum logic [1:0] {
      RK_CURRENT    = 2'd0,
      RK_AFTER_STOP = 2'd1,
      RK_LOADED_PC  = 2'd2,
      RK_RESET_SEQ  = 2'd3
   } resume_kind_e;
endpackage

// File: rtl/dbg_halt_prio.sv
module dbg_halt_prio #(
   parameter int NSRC = 4
) (
   input  logic [NSRC-1:0] src_i,
   output logic [NSRC-1:0] onehot_o,
   output logic            any_o
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("dbg_halt_prio: NSRC must be at least 1");
   end

   always_comb begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         onehot_o[i] = src_i[i] & ~seen;
         seen        = seen | src_i[i];
      end
      any_o = seen;
   end
endmodule

// File: rtl/dbg_run_fsm.sv
module dbg_run_fsm
   import dbg_run_pkg::*;
#(
   parameter int NSRC          = 4,
   parameter bit STOP_WAKE_ALL = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_i,
   input  logic            src_any_i,
   input  logic            stop_exec_i,
   input  logic            go_i,
   input  logic            core_reset_i,
   output run_state_e      state_o,
   output logic            entry_o,
   output logic            entry_stop_o,
   output logic            entry_reset_o,
   output logic            go_acc_o
);
   run_state_e state_q, state_d;
   logic       wake;

   // Which halt sources may leave the stopped state
   if (STOP_WAKE_ALL) begin : g_wake_all
      assign wake = src_any_i;
   end else begin : g_wake_pin
      assign wake = src_i[0];
   end

   always_comb begin
      state_d       = state_q;
      entry_o       = 1'b0;
      entry_stop_o  = 1'b0;
      entry_reset_o = 1'b0;
      go_acc_o      = 1'b0;
      if (core_reset_i) begin
         state_d       = RS_HALT;
         entry_o       = 1'b1;
         entry_reset_o = 1'b1;
      end else begin
         unique case (state_q)
            RS_RUN: begin
               if (src_any_i) begin
                  state_d = RS_HALT;
                  entry_o = 1'b1;
               end else if (stop_exec_i) begin
                  state_d = RS_STOP;
               end
            end
            RS_STOP: begin
               if (wake) begin
                  state_d      = RS_HALT;
                  entry_o      = 1'b1;
                  entry_stop_o = 1'b1;
               end
            end
            RS_HALT: begin
               if (go_i) begin
                  state_d  = RS_RUN;
                  go_acc_o = 1'b1;
               end
            end
            default: state_d = RS_RUN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= RS_RUN;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   // R10: reset indication always lands in halted
   a_r10_reset_halts: assert property (@(posedge clk) disable iff (!rst_n)
      core_reset_i |=> state_q == RS_HALT);
   // R4: stopped persists without any halt source
   a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RS_STOP && !core_reset_i && !src_any_i) |=> state_q == RS_STOP);
   // R7: GO outside halted never leads directly to running from stopped
   a_r7_go_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RS_STOP && go_i && !core_reset_i && !src_i[0]) |=> state_q == RS_STOP);
endmodule

// File: rtl/dbg_halt_status.sv
module dbg_halt_status #(
   parameter int NSRC   = 4,
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   onehot_i,
   input  logic              entry_i,
   input  logic              entry_reset_i,
   input  logic              clr_i,
   output logic [CODE_W-1:0] code_o
);
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] code_ext;

   if (NSRC > CODE_W) begin : g_bad_width
      $error("dbg_halt_status: NSRC must not exceed CODE_W");
   end else if (NSRC == CODE_W) begin : g_ext_eq
      assign code_ext = onehot_i;
   end else begin : g_ext_pad
      assign code_ext = {{(CODE_W-NSRC){1'b0}}, onehot_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          code_q <= '0;
      else if (entry_i)    code_q <= entry_reset_i ? '0 : code_ext;
      else if (clr_i)      code_q <= '0;
   end

   assign code_o = code_q;

   // R2: at most one cause is ever reported
   a_r2_code_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(code_q));
   // R9: code changes only on entry or clear
   a_r9_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!entry_i && !clr_i) |=> $stable(code_q));
endmodule

// File: rtl/dbg_resume_sel.sv
module dbg_resume_sel
   import dbg_run_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_halt_i,
   input  logic         entry_i,
   input  logic         entry_stop_i,
   input  logic         entry_reset_i,
   input  logic         go_acc_i,
   input  logic         pc_wr_i,
   output logic         resume_o,
   output resume_kind_e kind_o
);
   logic         pc_loaded_q;
   logic         ctx_stop_q;
   logic         ctx_reset_q;
   logic         resume_q;
   resume_kind_e kind_q;
   resume_kind_e kind_d;

   always_comb begin
      if (pc_loaded_q)      kind_d = RK_LOADED_PC;
      else if (ctx_reset_q) kind_d = RK_RESET_SEQ;
      else if (ctx_stop_q)  kind_d = RK_AFTER_STOP;
      else                  kind_d = RK_CURRENT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_loaded_q <= 1'b0;
         ctx_stop_q  <= 1'b0;
         ctx_reset_q <= 1'b0;
         resume_q    <= 1'b0;
         kind_q      <= RK_CURRENT;
      end else begin
         resume_q <= go_acc_i;
         if (entry_i) begin
            pc_loaded_q <= 1'b0;
            ctx_stop_q  <= entry_stop_i;
            ctx_reset_q <= entry_reset_i;
         end else if (go_acc_i) begin
            pc_loaded_q <= 1'b0;
            kind_q      <= kind_d;
         end else if (pc_wr_i && in_halt_i) begin
            pc_loaded_q <= 1'b1;
         end
      end
   end

   assign resume_o = resume_q;
   assign kind_o   = kind_q;

   // R6: a resume pulse follows a cycle spent halted
   a_r6_resume_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
      resume_q |-> $past(in_halt_i));
   // R6: the pulse lasts exactly one cycle
   a_r6_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
      resume_q |=> !resume_q);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
   import dbg_run_pkg::*;
#(
   parameter int NSRC          = 4,
   parameter int CODE_W        = 4,
   parameter bit STOP_WAKE_ALL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   halt_src_i,
   input  logic              stop_exec_i,
   input  logic              go_i,
   input  logic              core_reset_i,
   input  logic              pc_wr_i,
   input  logic              sts_clr_i,
   output logic [1:0]        run_state_o,
   output logic [CODE_W-1:0] halt_code_o,
   output logic              resume_o,
   output logic [1:0]        resume_kind_o,
   output logic              cmd_ok_o
);
   logic [NSRC-1:0] onehot;
   logic            src_any;
   run_state_e      state;
   logic            entry, entry_stop, entry_reset, go_acc;
   resume_kind_e    kind;

   dbg_halt_prio #(.NSRC(NSRC)) u_prio (
      .src_i    (halt_src_i),
      .onehot_o (onehot),
      .any_o    (src_any)
   );

   dbg_run_fsm #(.NSRC(NSRC), .STOP_WAKE_ALL(STOP_WAKE_ALL)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .src_i         (halt_src_i),
      .src_any_i     (src_any),
      .stop_exec_i   (stop_exec_i),
      .go_i          (go_i),
      .core_reset_i  (core_reset_i),
      .state_o       (state),
      .entry_o       (entry),
      .entry_stop_o  (entry_stop),
      .entry_reset_o (entry_reset),
      .go_acc_o      (go_acc)
   );

   dbg_halt_status #(.NSRC(NSRC), .CODE_W(CODE_W)) u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .onehot_i      (onehot),
      .entry_i       (entry),
      .entry_reset_i (entry_reset),
      .clr_i         (sts_clr_i),
      .code_o        (halt_code_o)
   );

   dbg_resume_sel u_resume (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_halt_i     (state == RS_HALT),
      .entry_i       (entry),
      .entry_stop_i  (entry_stop),
      .entry_reset_i (entry_reset),
      .go_acc_i      (go_acc),
      .pc_wr_i       (pc_wr_i),
      .resume_o      (resume_o),
      .kind_o        (kind)
   );

   assign run_state_o   = state;
   assign resume_kind_o = kind;
   assign cmd_ok_o      = (state == RS_HALT);

   // R11: halted stays halted unless GO or reset indication
   a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RS_HALT && !go_i) |=> run_state_o == 2'd2);
   // R5: commands allowed only while halted
   a_r5_cmd_window: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> !cmd_ok_o);
endmodule

// File: tb/dbg_halt_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_bench;
   localparam int NSRC = 4;
   localparam int CODE_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NSRC-1:0] src = '0;
   logic stp = 0, go = 0, crst = 0, pcw = 0, clr = 0;
   logic [1:0] st_o;
   logic [CODE_W-1:0] code_o;
   logic res_o;
   logic [1:0] kind_o;
   logic cmd_o;

   int n_tests = 0, n_fail = 0, cyc_cnt = 0;

   // reference model state
   int m_st = 0, m_code = 0, m_kind = 0;
   bit m_res = 0, m_pcl = 0, m_fst = 0, m_frs = 0;

   always #2.5 clk = ~clk;

   dbg_halt_ctrl #(.NSRC(NSRC), .CODE_W(CODE_W)) u_dbg_halt_ctrl (
      .clk(clk), .rst_n(rst_n), .halt_src_i(src), .stop_exec_i(stp),
      .go_i(go), .core_reset_i(crst), .pc_wr_i(pcw), .sts_clr_i(clr),
      .run_state_o(st_o), .halt_code_o(code_o), .resume_o(res_o),
      .resume_kind_o(kind_o), .cmd_ok_o(cmd_o));

   function automatic int top_src(logic [NSRC-1:0] s);
      for (int i = 0; i < NSRC; i++) if (s[i]) return (1 << i);
      return 0;
   endfunction

   function automatic int go_kind(bit pcl, bit frs, bit fst);
      if (pcl) return 2;
      if (frs) return 3;
      if (fst) return 1;
      return 0;
   endfunction

   task automatic model_step();
      bit entry = 0;
      m_res = 0;
      if (crst) begin
         m_st = 2; m_code = 0; m_pcl = 0; m_frs = 1; m_fst = 0; entry = 1;
      end else if (m_st == 0) begin
         if (src != 0) begin
            m_st = 2; m_code = top_src(src); m_pcl = 0; m_frs = 0; m_fst = 0; entry = 1;
         end else if (stp) m_st = 1;
      end else if (m_st == 1) begin
         if (src[0]) begin
            m_st = 2; m_code = 1; m_pcl = 0; m_frs = 0; m_fst = 1; entry = 1;
         end
      end else begin
         if (go) begin
            m_st = 0; m_res = 1; m_kind = go_kind(m_pcl, m_frs, m_fst); m_pcl = 0;
         end else if (pcw) m_pcl = 1;
      end
      if (!entry && clr) m_code = 0;
   endtask

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cmp_all(string tag);
      chk({tag, " state"}, st_o, m_st);
      chk({tag, " code"}, code_o, m_code);
      chk({tag, " resume"}, res_o, m_res);
      chk({tag, " kind"}, kind_o, m_kind);
      chk({tag, " cmd_ok R5"}, cmd_o, (m_st == 2));
   endtask

   task automatic cyc(string tag);
      model_step();
      @(posedge clk);
      @(negedge clk);
      cmp_all(tag);
      src = '0; stp = 0; go = 0; crst = 0; pcw = 0; clr = 0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc_cnt++;
         if (cyc_cnt > 50000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd715));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 state", st_o, 0); chk("R1 code", code_o, 0);
      chk("R1 cmd_ok", cmd_o, 0); chk("R1 resume", res_o, 0); chk("R1 kind", kind_o, 0);

      src = 4'b0110; cyc("R2 priority hw over sw");
      chk("R2 code", code_o, 2);
      src = 4'b0001; cyc("R11 source while halted");
      chk("R11 code held", code_o, 2);
      go = 1; cyc("R6 go plain");
      chk("R6 kind current", kind_o, 0);
      cyc("R6 pulse ends");
      go = 1; cyc("R7 go while running");
      chk("R7 no resume", res_o, 0);

      stp = 1; cyc("R3 enter stop");
      src = 4'b1110; cyc("R4 non-pin source in stop");
      chk("R4 still stopped", st_o, 1);
      go = 1; cyc("R7 go while stopped");
      src = 4'b0001; cyc("R4 pin wakes stop");
      go = 1; cyc("R6 after stop");
      chk("R6 kind after stop", kind_o, 1);

      crst = 1; cyc("R10 reset halt");
      chk("R10 code zero", code_o, 0);
      pcw = 1; cyc("R6 pc written");
      go = 1; cyc("R6 loaded pc");
      chk("R6 kind loaded", kind_o, 2);
      crst = 1; cyc("R10 reset again");
      go = 1; cyc("R8 pc flag cleared");
      chk("R8 kind reset seq", kind_o, 3);

      src = 4'b1000; cyc("R2 fault-on-fault");
      clr = 1; cyc("R9 clear");
      chk("R9 cleared", code_o, 0);
      go = 1; cyc("R9 leave");
      src = 4'b0100; clr = 1; cyc("R9 entry beats clear");
      chk("R9 entry wins", code_o, 4);
      crst = 1; src = 4'b0001; go = 1; cyc("R10 reset priority");

      for (int k = 0; k < 4000; k++) begin
         if ($urandom % 8 == 0) src = NSRC'($urandom % 15 + 1);
         stp  = ($urandom % 6 == 0);
         go   = ($urandom % 4 == 0);
         crst = ($urandom % 40 == 0);
         pcw  = ($urandom % 5 == 0);
         clr  = ($urandom % 10 == 0);
         cyc("R2/R3/R4/R6/R7/R8/R9/R10/R11 random");
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule